// File: doc/BRIEF.md
# Serial Port Register Block with Watermark Interrupts

This block is a serial port peripheral for a small system-on-chip. Software reaches it through a 32-bit register bus that accepts whole-word accesses only. The bus holds four programmable registers:

- transmit control
- receive control
- interrupt enable
- baud divisor

A write to the transmit data word sends one byte straight to an 8N1 serial transmitter. No transmit queue sits in front of the transmitter. An 8N1 serial receiver fills an eight-entry receive queue, and software empties that queue by reading the receive data word.

The block drives one level interrupt. Two pending conditions feed it. Each condition compares a live quantity against a small watermark count held in a control register. The receive condition uses the queue occupancy. The transmitter is always treated as drained, so the transmit condition depends only on its programmed count. Both serial engines time each bit from the divisor.

Top module: `uart_wm_top`

## Requirements
- R1: A full-word read of the receive data word (offset 0x04) while the receive queue holds bytes returns the oldest byte in bits 7:0, with zeros above. The read removes that byte, so the next read returns the following byte in arrival order.
- R2: A full-word read of the receive data word while the receive queue is empty returns 0x80000000. Bit 31 is the empty flag, and the data bits are zero.
- R3: Pending bit 1 (receive watermark) in the pending word (offset 0x14) is 1 exactly when the number of queued receive bytes is strictly greater than bits 18:16 of receive control (offset 0x0C).
- R4: Pending bit 0 (transmit watermark) is 1 exactly when bits 18:16 of transmit control (offset 0x08) are nonzero. All other pending bits read 0.
- R5: `irq` is high when interrupt-enable (offset 0x10) bit 0 is set. It is also high when interrupt-enable bit 1 is set and the receive queue is not empty. Otherwise it is low.
- R6: The receive queue holds 8 bytes. A byte that completes while the queue is full is dropped, and the queued bytes are unchanged. `rx_space` is low exactly while the queue is full.
- R7: A full-word write to transmit data (offset 0x00) is accepted only when transmit-control bit 0 is set and no frame is in progress. An accepted write sends bits 7:0 of the written word as one start bit (0), eight data bits LSB first and one stop bit (1). Each bit lasts divisor+1 clocks. Any other transmit write is ignored. Reading transmit data returns 0.
- R8: Interrupt enable, transmit control and receive control read back the last full word written. The divisor (offset 0x18) reads back the low 16 bits written, with zeros above, and resets to 15. The other registers reset to 0. The pending word is read-only.
- R9: Accesses whose byte enables are not all set are ignored: such a write changes nothing, and such a read returns 0. Reads of unmapped offsets (0x1C and above) return 0, and writes to them are ignored.
- R10: The receiver takes frames only while receive-control bit 0 is set. It samples each bit at mid-bit and discards any frame whose stop bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_be | input | 4 | Byte enables; only 4'hF is a valid access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rx_line | input | 1 | Serial receive input, idle high |
| rx_space | output | 1 | Receive queue can accept a byte |
| tx_line | output | 1 | Serial transmit output, idle high |
| irq | output | 1 | Level interrupt |

## Verification
The receive path is driven with three kinds of traffic:

- **Fixed short bursts around the watermark count.** A burst that stops at the count and one that goes a byte past it separate a strict comparison from a greater-or-equal one.
- **A burst of ten bytes against the eight-entry queue.** This shows whether overflow keeps the oldest bytes or overwrites them.
- **Random-length bursts with random payloads and random watermark counts.** These are checked against a queue model in the bench and exercise ordering and pointer wrap.

Two malformed or unwanted inputs must leave the queue empty: a frame with a low stop bit, and traffic sent while receive is disabled. On the transmit side, a captured frame is compared bit by bit. A second write during a frame and a write while transmit is disabled must each produce no line activity.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
    localparam int REG_W   = 32;
    localparam int WM_LO   = 16;
    localparam int WM_HI   = 18;
    localparam int EN_BIT  = 0;
    localparam int IE_TX   = 0;
    localparam int IE_RX   = 1;

    localparam logic [4:0] OFS_TXDATA = 5'h00;
    localparam logic [4:0] OFS_RXDATA = 5'h04;
    localparam logic [4:0] OFS_TXCTL  = 5'h08;
    localparam logic [4:0] OFS_RXCTL  = 5'h0C;
    localparam logic [4:0] OFS_IE     = 5'h10;
    localparam logic [4:0] OFS_IP     = 5'h14;
    localparam logic [4:0] OFS_DIV    = 5'h18;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_st_e;
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/uart_wm_tx.sv
module uart_wm_tx
    import uart_wm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       byte_in,
    input  logic [DIV_W-1:0] div,
    output logic             line,
    output logic             busy
);
    typedef struct packed {
        line_st_e         st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             line;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.st != LN_IDLE && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            case (st_q.st)
                LN_IDLE: begin
                    st_d.line = 1'b1;
                    if (load) begin
                        st_d.st   = LN_START;
                        st_d.line = 1'b0;
                        st_d.cnt  = div;
                        st_d.sh   = byte_in;
                    end
                end
                LN_START: begin
                    st_d.st   = LN_DATA;
                    st_d.line = st_q.sh[0];
                    st_d.sh   = st_q.sh >> 1;
                    st_d.idx  = '0;
                    st_d.cnt  = div;
                end
                LN_DATA: begin
                    st_d.cnt = div;
                    if (st_q.idx == 3'd7) begin
                        st_d.st   = LN_STOP;
                        st_d.line = 1'b1;
                    end else begin
                        st_d.line = st_q.sh[0];
                        st_d.sh   = st_q.sh >> 1;
                        st_d.idx  = st_q.idx + 1'b1;
                    end
                end
                default: begin
                    st_d.st   = LN_IDLE;
                    st_d.line = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= LN_IDLE;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.line;
    assign busy = (st_q.st != LN_IDLE);
endmodule

// File: rtl/uart_wm_rx.sv
module uart_wm_rx
    import uart_wm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line_in,
    input  logic [DIV_W-1:0] div,
    output logic             valid,
    output logic [7:0]       data
);
    typedef struct packed {
        logic [1:0]       sync;
        line_st_e         st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             valid;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   s;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sync  = {st_q.sync[0], line_in};
        s          = st_q.sync[1];
        if (st_q.st != LN_IDLE && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            case (st_q.st)
                LN_IDLE: begin
                    if (en && !s) begin
                        st_d.st  = LN_START;
                        st_d.cnt = div >> 1;
                    end
                end
                LN_START: begin
                    st_d.cnt = div;
                    st_d.idx = '0;
                    st_d.st  = s ? LN_IDLE : LN_DATA;
                end
                LN_DATA: begin
                    st_d.sh  = {s, st_q.sh[7:1]};
                    st_d.cnt = div;
                    if (st_q.idx == 3'd7) st_d.st = LN_STOP;
                    else                  st_d.idx = st_q.idx + 1'b1;
                end
                default: begin
                    st_d.st    = LN_IDLE;
                    st_d.valid = s;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= LN_IDLE;
            st_q.sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign data  = st_q.sh;
endmodule

// File: rtl/uart_wm_top.sv
module uart_wm_top
    import uart_wm_pkg::*;
#(
    parameter int          ADDR_W    = 5,
    parameter int          RX_DEPTH  = 8,
    parameter int          DIV_W     = 16,
    parameter logic [15:0] DIV_RESET = 16'd15,
    localparam int         CW        = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [REG_W-1:0]  req_wdata,
    output logic [REG_W-1:0]  rsp_rdata,
    input  logic              rx_line,
    output logic              rx_space,
    output logic              tx_line,
    output logic              irq
);
    typedef struct packed {
        logic [REG_W-1:0] ie;
        logic [REG_W-1:0] txc;
        logic [REG_W-1:0] rxc;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t           regs_d, regs_q;
    logic            acc_ok, wr, rd;
    logic            rx_push, rx_pop, tx_load, tx_busy;
    logic [7:0]      rx_byte, rx_head;
    logic [CW-1:0]   rx_cnt;
    logic [REG_W-1:0] pend;

    always_comb begin
        regs_d  = regs_q;
        acc_ok  = req_valid && (req_be == 4'hF);
        wr      = acc_ok && req_write;
        rd      = acc_ok && !req_write;
        rx_pop  = rd && (req_addr == ADDR_W'(OFS_RXDATA)) && (rx_cnt != '0);
        tx_load = wr && (req_addr == ADDR_W'(OFS_TXDATA))
                  && regs_q.txc[EN_BIT] && !tx_busy;

        pend        = '0;
        pend[IE_TX] = (regs_q.txc[WM_HI:WM_LO] != '0);
        pend[IE_RX] = (32'(rx_cnt) > 32'(regs_q.rxc[WM_HI:WM_LO]));

        if (wr) begin
            case (req_addr)
                ADDR_W'(OFS_TXCTL): regs_d.txc = req_wdata;
                ADDR_W'(OFS_RXCTL): regs_d.rxc = req_wdata;
                ADDR_W'(OFS_IE):    regs_d.ie  = req_wdata;
                ADDR_W'(OFS_DIV):   regs_d.div = req_wdata[DIV_W-1:0];
                default: ;
            endcase
        end

        rsp_rdata = '0;
        if (rd) begin
            case (req_addr)
                ADDR_W'(OFS_RXDATA): rsp_rdata = (rx_cnt != '0)
                                         ? {24'h0, rx_head} : 32'h8000_0000;
                ADDR_W'(OFS_TXCTL):  rsp_rdata = regs_q.txc;
                ADDR_W'(OFS_RXCTL):  rsp_rdata = regs_q.rxc;
                ADDR_W'(OFS_IE):     rsp_rdata = regs_q.ie;
                ADDR_W'(OFS_IP):     rsp_rdata = pend;
                ADDR_W'(OFS_DIV):    rsp_rdata = REG_W'(regs_q.div);
                default:             rsp_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.div <= DIV_W'(DIV_RESET);
        end else begin
            regs_q <= regs_d;
        end
    end

    uart_wm_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt)
    );

    uart_wm_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(regs_q.rxc[EN_BIT]), .line_in(rx_line),
        .div(regs_q.div), .valid(rx_push), .data(rx_byte)
    );

    uart_wm_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .byte_in(req_wdata[7:0]),
        .div(regs_q.div), .line(tx_line), .busy(tx_busy)
    );

    assign rx_space = (rx_cnt != CW'(RX_DEPTH));
    assign irq      = regs_q.ie[IE_TX] || (regs_q.ie[IE_RX] && rx_cnt != '0);
endmodule

// File: rtl/uart_wm_chk.sv
module uart_wm_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 5,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic [31:0]       rsp_rdata,
    input logic              tx_line,
    input logic              irq,
    input logic [CW-1:0]     cnt,
    input logic              push,
    input logic              tx_busy,
    input logic              tx_en,
    input logic [1:0]        ie_bits
);
    logic rd_rx, wr_tx, rd_hi;
    assign rd_rx = req_valid && !req_write && req_be == 4'hF && req_addr == ADDR_W'(5'h04);
    assign wr_tx = req_valid && req_write && req_be == 4'hF && req_addr == ADDR_W'(5'h00);
    assign rd_hi = req_valid && !req_write && req_addr >= ADDR_W'(5'h1C);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_full_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && push && !rd_rx) |=> cnt == CW'(DEPTH));

    assert_empty_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && cnt == '0) |-> rsp_rdata == 32'h8000_0000);

    assert_pop_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && cnt != '0 && !push) |=> cnt == $past(cnt) - 1'b1);

    assert_tx_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_en && !tx_busy) |=> !tx_line);

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_bits[0] && cnt == '0) |-> !irq);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> rsp_rdata == '0);
endmodule

bind uart_wm_top uart_wm_chk #(.DEPTH(RX_DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .rsp_rdata(rsp_rdata),
    .tx_line(tx_line), .irq(irq), .cnt(rx_cnt), .push(rx_push),
    .tx_busy(tx_busy), .tx_en(regs_q.txc[0]), .ie_bits(regs_q.ie[1:0])
);

// File: tb/uart_wm_top_tb.sv
module uart_wm_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 7;
    localparam int BIT        = DIV + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rx_line = 1'b1;
    logic        rx_space, tx_line, irq;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] model_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_wm_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rx_line(rx_line), .rx_space(rx_space),
        .tx_line(tx_line), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ip(input logic [31:0] txc, input logic [31:0] rxc,
                                           input int n);
        exp_ip = 32'h0;
        exp_ip[0] = (txc[18:16] != 0);
        exp_ip[1] = (n > int'(rxc[18:16]));
    endfunction

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                             input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_be = 4'hF;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d,
                            input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_be = be;
        #1 d = rsp_rdata;
        @(negedge clk);
        req_valid = 0; req_be = 4'hF;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rx_line = 0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx_line = stop;
        repeat (BIT) @(negedge clk);
        rx_line = 1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic tx_capture(output logic [7:0] b, output bit ok);
        int t = 0;
        ok = 1;
        b = '0;
        while (tx_line && t < 2000) begin @(negedge clk); t++; end
        if (tx_line) begin ok = 0; return; end
        repeat (BIT/2) @(negedge clk);
        if (tx_line) ok = 0;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = tx_line;
        end
        repeat (BIT) @(negedge clk);
        if (!tx_line) ok = 0;
    endtask

    task automatic line_quiet(input int cycles, output bit quiet);
        quiet = 1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!tx_line) quiet = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, v, txc, rxc;
        logic [7:0]  b;
        bit ok, q;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        check("R5 reset irq", {31'b0, irq}, 0);
        bus_read(5'h04, r); check("R2 empty read", r, 32'h8000_0000);
        bus_read(5'h18, r); check("R8 divisor reset", r, 32'd15);
        bus_read(5'h10, r); check("R8 ie reset", r, 0);
        bus_read(5'h00, r); check("R7 txdata reads 0", r, 0);
        bus_read(5'h14, r); check("R4 pending reset", r, 0);

        // R8 readback
        v = $urandom; bus_write(5'h10, v); bus_read(5'h10, r); check("R8 ie readback", r, v);
        v = $urandom; bus_write(5'h08, v); bus_read(5'h08, r); check("R8 txc readback", r, v);
        v = $urandom; bus_write(5'h0C, v); bus_read(5'h0C, r); check("R8 rxc readback", r, v);
        v = $urandom; bus_write(5'h18, v); bus_read(5'h18, r); check("R8 div readback", r, v & 32'hFFFF);
        bus_write(5'h18, DIV); bus_write(5'h10, 0);
        txc = 1; rxc = 1;
        bus_write(5'h08, txc); bus_write(5'h0C, rxc);

        // R9 unmapped and partial accesses
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_read(5'h1C, r); check("R9 unmapped read", r, 0);
        bus_write(5'h08, 32'h0007_0000, 4'h3);
        bus_read(5'h08, r); check("R9 partial write ignored", r, txc);
        bus_read(5'h08, r, 4'h1); check("R9 partial read zero", r, 0);
        bus_write(5'h14, 32'hFFFF_FFFF);
        bus_read(5'h14, r); check("R8 pending read-only", r, 0);

        // R4 transmit watermark
        txc = 32'h0003_0001; bus_write(5'h08, txc);
        bus_read(5'h14, r); check("R4 tx wm set", r, 32'h1);
        txc = 32'h1; bus_write(5'h08, txc);
        bus_read(5'h14, r); check("R4 tx wm clear", r, 0);

        // R3 receive watermark strict compare, R1 order
        rxc = 32'h0002_0001; bus_write(5'h0C, rxc);
        send_frame(8'h11, 1); send_frame(8'h22, 1);
        bus_read(5'h14, r); check("R3 at count no pend", r, 0);
        send_frame(8'h33, 1);
        bus_read(5'h14, r); check("R3 above count pend", r, 32'h2);
        bus_read(5'h04, r); check("R1 first byte", r, 32'h11);
        bus_read(5'h04, r); check("R1 second byte", r, 32'h22);
        bus_read(5'h04, r); check("R1 third byte", r, 32'h33);
        bus_read(5'h04, r); check("R2 empty after drain", r, 32'h8000_0000);

        // R5 interrupt
        bus_write(5'h10, 32'h2);
        check("R5 rx en empty low", {31'b0, irq}, 0);
        send_frame(8'h5A, 1);
        check("R5 rx en nonempty high", {31'b0, irq}, 1);
        bus_read(5'h04, r);
        check("R5 after drain low", {31'b0, irq}, 0);
        bus_write(5'h10, 32'h1);
        check("R5 tx en high", {31'b0, irq}, 1);
        bus_write(5'h10, 32'h0);

        // R6 overflow
        for (int i = 0; i < 10; i++) send_frame(8'h40 + 8'(i), 1);
        check("R6 rx_space low when full", {31'b0, rx_space}, 0);
        for (int i = 0; i < 8; i++) begin
            bus_read(5'h04, r); check("R6 kept oldest", r, 32'h40 + 32'(i));
        end
        bus_read(5'h04, r); check("R6 extra dropped", r, 32'h8000_0000);
        check("R6 rx_space high", {31'b0, rx_space}, 1);

        // R10 bad stop and disabled receiver
        send_frame(8'h77, 0);
        bus_read(5'h04, r); check("R10 bad stop discarded", r, 32'h8000_0000);
        bus_write(5'h0C, 0);
        send_frame(8'h66, 1);
        bus_read(5'h04, r); check("R10 disabled ignored", r, 32'h8000_0000);
        bus_write(5'h0C, 1);

        // R7 transmit
        bus_write(5'h00, 32'h0000_01A5);
        bus_write(5'h00, 32'h0000_0000);
        tx_capture(b, ok);
        check("R7 frame shape", {31'b0, ok}, 1);
        check("R7 tx byte", {24'b0, b}, 32'hA5);
        line_quiet(3 * 10 * BIT, q);
        check("R7 busy write ignored", {31'b0, q}, 1);
        bus_write(5'h08, 0);
        bus_write(5'h00, 32'h0000_0000);
        line_quiet(2 * 10 * BIT, q);
        check("R7 disabled ignored", {31'b0, q}, 1);
        bus_write(5'h08, 1);
        v = $urandom;
        bus_write(5'h00, v);
        tx_capture(b, ok);
        check("R7 random tx byte", {24'b0, b}, {24'b0, v[7:0]});

        // Random receive bursts
        for (int it = 0; it < 15; it++) begin
            int n;
            n = 1 + int'($urandom % 6);
            rxc = {13'b0, 3'($urandom), 15'b0, 1'b1};
            bus_write(5'h0C, rxc);
            for (int k = 0; k < n; k++) begin
                b = 8'($urandom);
                model_q.push_back(b);
                send_frame(b, 1);
            end
            bus_read(5'h14, r);
            check("R3 random pend", r, exp_ip(txc, rxc, model_q.size()));
            while (model_q.size() > 0) begin
                bus_read(5'h04, r);
                check("R1 random order", r, {24'b0, model_q.pop_front()});
            end
            bus_read(5'h04, r); check("R2 random empty", r, 32'h8000_0000);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule